// File: doc/BRIEF.md
# Tagged Two-Way Pattern Table Allocator

This block stores the per-branch entries of a repeating-pattern branch predictor. It is a small set-associative table: every set has two ways, and each way holds a valid bit, a partial tag, a saturating usefulness counter, a local outcome history and a fill count. Only the storage and the replacement policy live here. The pattern-matching logic and the main predictor sit outside and feed their verdicts in.

The lookup side is combinational. The caller presents a set index and a partial tag. The table answers with hit, way, usefulness, history and fill count, and all of these read zero on a miss.

Resolved branches arrive on a valid/ready resolve channel. A beat is taken only in a cycle where `rs_valid` and `rs_ready` are both high. On a tag hit, the table adjusts the way's usefulness and shifts the outcome into its history. On a miss that the main predictor also got wrong, the table installs the branch in a way whose usefulness is zero. A counter of accepted beats ages the table: when it wraps, every usefulness field is cleared in the following cycle. `rs_ready` is low in that one cycle only, so the producer must hold its beat for one cycle. Lookups may continue while `rs_ready` is low.

Top module: `pattern_tag_table`

## Requirements
- R1: After reset no lookup hits, `rs_ready` is high, and every lookup output reads zero.
- R2: On allocation, way 0 is taken if its usefulness is zero. Otherwise way 1 is taken if its usefulness is zero.
- R3: An accepted resolve that misses on tag allocates only when `rs_main_miss` is 1. With `rs_main_miss` at 0 the table is left unchanged.
- R4: A newly installed entry holds the resolve tag, has usefulness equal to its maximum (all ones), and has its history and fill count at zero.
- R5: A resolve that misses on tag, with both ways of the set holding nonzero usefulness, installs nothing.
- R6: On a tag hit with `rs_pat_rdy`=1, usefulness rises by one when `rs_pat_ok`=1 and `rs_main_miss`=1. It holds when both predictions were right, and also when both were wrong.
- R7: On a tag hit, usefulness drops by one when `rs_pat_rdy`=0. It also drops when `rs_pat_ok`=0 while `rs_main_miss`=0.
- R8: Usefulness saturates at zero and at its maximum.
- R9: On a tag hit, the history becomes {history[HIST_W-2:0], `rs_taken`}, with the newest outcome in bit 0. The fill count rises by one and saturates at all ones.
- R10: The resolve that brings the accepted-beat count to 2^AGE_W wraps the count. In the next cycle every usefulness field is cleared and `rs_ready` is low. In the cycle after that, `rs_ready` is high again.
- R11: A lookup hits when a valid way of the indexed set holds the presented tag. `lk_way` gives that way, and no set ever holds one tag in both ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_idx | input | SET_W | Lookup set index |
| lk_tag | input | TAG_W | Lookup partial tag |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 1 | Way that hit |
| lk_use | output | USE_W | Usefulness of the hit way |
| lk_hist | output | HIST_W | Outcome history of the hit way |
| lk_fill | output | FILL_W | Fill count of the hit way |
| rs_valid | input | 1 | Resolve beat present |
| rs_ready | output | 1 | Resolve beat can be taken |
| rs_idx | input | SET_W | Resolve set index |
| rs_tag | input | TAG_W | Resolve partial tag |
| rs_main_miss | input | 1 | Main predictor was wrong |
| rs_pat_ok | input | 1 | Pattern guess was right |
| rs_pat_rdy | input | 1 | Pattern entry had a guess ready |
| rs_taken | input | 1 | Resolved branch outcome |

## Verification
The bench aims at the following corner cases:
- **Replacement preference.** It fills one set until both ways are busy, then wears one way down to zero. A wrong victim choice would evict the busy way or skip the idle one.
- **Counter limits.** It drives usefulness past both limits. An unsaturated counter would wrap from 7 to 0, or from 0 to 7, and flip an entry's standing.
- **Aging clear.** It runs the beat counter through its wrap. A clear issued in the wrong cycle, or a ready gap that is missing or lasts too long, would show up as usefulness surviving, or as a beat being dropped or taken twice.
- **Random traffic.** A long stretch over few tags keeps entries being evicted and reinstalled. A duplicated tag or a stale history would then diverge from the model.

// File: rtl/ptab_pkg.sv
package ptab_pkg;

  // Direction of a usefulness adjustment on a tag hit.
  typedef enum logic [1:0] {
    UDIR_HOLD = 2'd0,
    UDIR_INC  = 2'd1,
    UDIR_DEC  = 2'd2
  } udir_e;

  localparam int unsigned NWAYS = 2;

endpackage

// File: rtl/ptab_way_store.sv
module ptab_way_store #(
  parameter int unsigned SET_W  = 4,
  parameter int unsigned TAG_W  = 7,
  parameter int unsigned USE_W  = 3,
  parameter int unsigned HIST_W = 8,
  parameter int unsigned FILL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup read port
  input  logic [SET_W-1:0]  lk_idx,
  output logic              lk_vld,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [USE_W-1:0]  lk_use,
  output logic [HIST_W-1:0] lk_hist,
  output logic [FILL_W-1:0] lk_fill,
  // resolve read port
  input  logic [SET_W-1:0]  rs_idx,
  output logic              rs_vld,
  output logic [TAG_W-1:0]  rs_tag,
  output logic [USE_W-1:0]  rs_use,
  output logic [HIST_W-1:0] rs_hist,
  output logic [FILL_W-1:0] rs_fill,
  // write port, addressed by rs_idx
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [USE_W-1:0]  wr_use,
  input  logic [HIST_W-1:0] wr_hist,
  input  logic [FILL_W-1:0] wr_fill,
  input  logic              age_clr
);

  localparam int unsigned SETS = 1 << SET_W;

  logic              vld_q  [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [USE_W-1:0]  use_q  [SETS];
  logic [HIST_W-1:0] hist_q [SETS];
  logic [FILL_W-1:0] fill_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= 1'b0;
        tag_q[s]  <= '0;
        use_q[s]  <= '0;
        hist_q[s] <= '0;
        fill_q[s] <= '0;
      end
    end else if (age_clr) begin
      for (int s = 0; s < SETS; s++) use_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[rs_idx]  <= 1'b1;
      tag_q[rs_idx]  <= wr_tag;
      use_q[rs_idx]  <= wr_use;
      hist_q[rs_idx] <= wr_hist;
      fill_q[rs_idx] <= wr_fill;
    end
  end

  assign lk_vld  = vld_q[lk_idx];
  assign lk_tag  = tag_q[lk_idx];
  assign lk_use  = use_q[lk_idx];
  assign lk_hist = hist_q[lk_idx];
  assign lk_fill = fill_q[lk_idx];

  assign rs_vld  = vld_q[rs_idx];
  assign rs_tag  = tag_q[rs_idx];
  assign rs_use  = use_q[rs_idx];
  assign rs_hist = hist_q[rs_idx];
  assign rs_fill = fill_q[rs_idx];

endmodule

// File: rtl/ptab_victim_sel.sv
module ptab_victim_sel (
  input  logic       accept,
  input  logic       main_miss,
  input  logic       hit_any,
  input  logic [1:0] use_zero,
  output logic       alloc_en,
  output logic       alloc_way
);

  // Way 0 wins when both ways are idle.
  assign alloc_en  = accept && main_miss && !hit_any && (|use_zero);
  assign alloc_way = !use_zero[0];

endmodule

// File: rtl/ptab_age_timer.sv
module ptab_age_timer #(
  parameter int unsigned AGE_W = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic wrap,
  output logic clr_pend
);

  logic [AGE_W-1:0] cnt_q;

  assign wrap = tick && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      clr_pend <= 1'b0;
    end else begin
      if (tick) cnt_q <= cnt_q + 1'b1;
      clr_pend <= wrap;
    end
  end

endmodule

// File: rtl/pattern_tag_table.sv
module pattern_tag_table
  import ptab_pkg::*;
#(
  parameter int unsigned SET_W  = 4,
  parameter int unsigned TAG_W  = 7,
  parameter int unsigned USE_W  = 3,
  parameter int unsigned HIST_W = 8,
  parameter int unsigned FILL_W = 4,
  parameter int unsigned AGE_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic              lk_way,
  output logic [USE_W-1:0]  lk_use,
  output logic [HIST_W-1:0] lk_hist,
  output logic [FILL_W-1:0] lk_fill,
  input  logic              rs_valid,
  output logic              rs_ready,
  input  logic [SET_W-1:0]  rs_idx,
  input  logic [TAG_W-1:0]  rs_tag,
  input  logic              rs_main_miss,
  input  logic              rs_pat_ok,
  input  logic              rs_pat_rdy,
  input  logic              rs_taken
);

  localparam logic [USE_W-1:0]  USE_MAX  = '1;
  localparam logic [FILL_W-1:0] FILL_MAX = '1;

  // per-way read data
  logic              l_vld  [NWAYS];
  logic [TAG_W-1:0]  l_tag  [NWAYS];
  logic [USE_W-1:0]  l_use  [NWAYS];
  logic [HIST_W-1:0] l_hist [NWAYS];
  logic [FILL_W-1:0] l_fill [NWAYS];
  logic              r_vld  [NWAYS];
  logic [TAG_W-1:0]  r_tag  [NWAYS];
  logic [USE_W-1:0]  r_use  [NWAYS];
  logic [HIST_W-1:0] r_hist [NWAYS];
  logic [FILL_W-1:0] r_fill [NWAYS];

  logic [NWAYS-1:0] lk_match, rs_match, use_zero, wr_en;
  logic             accept, rs_hit_any, alloc_en, alloc_way;
  logic             age_wrap, age_clr;

  logic [TAG_W-1:0]  wr_tag;
  logic [USE_W-1:0]  wr_use;
  logic [HIST_W-1:0] wr_hist;
  logic [FILL_W-1:0] wr_fill;

  assign rs_ready = !age_clr;
  assign accept   = rs_valid && rs_ready;

  generate
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
      ptab_way_store #(
        .SET_W(SET_W), .TAG_W(TAG_W), .USE_W(USE_W),
        .HIST_W(HIST_W), .FILL_W(FILL_W)
      ) store_i (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_vld(l_vld[w]), .lk_tag(l_tag[w]), .lk_use(l_use[w]),
        .lk_hist(l_hist[w]), .lk_fill(l_fill[w]),
        .rs_idx(rs_idx), .rs_vld(r_vld[w]), .rs_tag(r_tag[w]), .rs_use(r_use[w]),
        .rs_hist(r_hist[w]), .rs_fill(r_fill[w]),
        .wr_en(wr_en[w]), .wr_tag(wr_tag), .wr_use(wr_use),
        .wr_hist(wr_hist), .wr_fill(wr_fill), .age_clr(age_clr)
      );

      assign lk_match[w] = l_vld[w] && (l_tag[w] == lk_tag);
      assign rs_match[w] = r_vld[w] && (r_tag[w] == rs_tag);
      assign use_zero[w] = (r_use[w] == '0);
      assign wr_en[w]    = accept && (rs_match[w] || (alloc_en && (alloc_way == 1'(w))));
    end
  endgenerate

  // lookup result: all zero on a miss
  always_comb begin
    lk_hit  = |lk_match;
    lk_way  = lk_match[1];
    lk_use  = '0;
    lk_hist = '0;
    lk_fill = '0;
    if (lk_hit) begin
      lk_use  = l_use[lk_way];
      lk_hist = l_hist[lk_way];
      lk_fill = l_fill[lk_way];
    end
  end

  assign rs_hit_any = |rs_match;

  ptab_victim_sel victim_i (
    .accept(accept), .main_miss(rs_main_miss), .hit_any(rs_hit_any),
    .use_zero(use_zero), .alloc_en(alloc_en), .alloc_way(alloc_way)
  );

  ptab_age_timer #(.AGE_W(AGE_W)) age_i (
    .clk(clk), .rst_n(rst_n), .tick(accept), .wrap(age_wrap), .clr_pend(age_clr)
  );

  // next-state values for the written way
  udir_e             udir;
  logic              h_way;
  logic [USE_W-1:0]  h_use;
  logic [HIST_W-1:0] h_hist;
  logic [FILL_W-1:0] h_fill;

  assign h_way  = rs_match[1];
  assign h_use  = r_use[h_way];
  assign h_hist = r_hist[h_way];
  assign h_fill = r_fill[h_way];

  always_comb begin
    if (!rs_pat_rdy)                    udir = UDIR_DEC;
    else if (rs_pat_ok && rs_main_miss)   udir = UDIR_INC;
    else if (!rs_pat_ok && !rs_main_miss) udir = UDIR_DEC;
    else                                  udir = UDIR_HOLD;
  end

  always_comb begin
    if (rs_hit_any) begin
      wr_tag = rs_tag;
      unique case (udir)
        UDIR_INC: wr_use = (h_use == USE_MAX) ? h_use : h_use + 1'b1;
        UDIR_DEC: wr_use = (h_use == '0) ? h_use : h_use - 1'b1;
        default:  wr_use = h_use;
      endcase
      wr_hist = {h_hist[HIST_W-2:0], rs_taken};
      wr_fill = (h_fill == FILL_MAX) ? h_fill : h_fill + 1'b1;
    end else begin
      wr_tag  = rs_tag;
      wr_use  = USE_MAX;
      wr_hist = '0;
      wr_fill = '0;
    end
  end

endmodule

// File: rtl/ptab_alloc_chk.sv
module ptab_alloc_chk #(
  parameter int unsigned USE_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       lk_match,
  input logic             alloc_en,
  input logic             alloc_way,
  input logic             rs_hit_any,
  input logic             rs_main_miss,
  input logic             rs_ready,
  input logic             age_wrap,
  input logic [USE_W-1:0] use0,
  input logic [USE_W-1:0] use1
);

  assert_single_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lk_match) <= 1);

  assert_alloc_needs_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (rs_main_miss && !rs_hit_any));

  assert_victim_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (alloc_way ? (use1 == '0 && use0 != '0) : (use0 == '0)));

  assert_ready_gap_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_ready |=> rs_ready);

  assert_ready_after_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    age_wrap |=> !rs_ready);

endmodule

bind pattern_tag_table ptab_alloc_chk #(.USE_W(USE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_match(lk_match), .alloc_en(alloc_en),
  .alloc_way(alloc_way), .rs_hit_any(rs_hit_any), .rs_main_miss(rs_main_miss),
  .rs_ready(rs_ready), .age_wrap(age_wrap), .use0(r_use[0]), .use1(r_use[1])
);

// File: tb/pattern_tag_table_tb_top.sv
module pattern_tag_table_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SET_W  = 2;
  localparam int TAG_W  = 7;
  localparam int USE_W  = 3;
  localparam int HIST_W = 8;
  localparam int FILL_W = 4;
  localparam int AGE_W  = 6;
  localparam int SETS   = 1 << SET_W;
  localparam int UMAX   = (1 << USE_W) - 1;
  localparam int FMAX   = (1 << FILL_W) - 1;
  localparam int HMASK  = (1 << HIST_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SET_W-1:0]  lk_idx = '0;
  logic [TAG_W-1:0]  lk_tag = '0;
  logic              lk_hit, lk_way, rs_ready;
  logic [USE_W-1:0]  lk_use;
  logic [HIST_W-1:0] lk_hist;
  logic [FILL_W-1:0] lk_fill;
  logic              rs_valid = 1'b0;
  logic [SET_W-1:0]  rs_idx = '0;
  logic [TAG_W-1:0]  rs_tag = '0;
  logic rs_main_miss = 1'b0, rs_pat_ok = 1'b0, rs_pat_rdy = 1'b0, rs_taken = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_tag_table #(
    .SET_W(SET_W), .TAG_W(TAG_W), .USE_W(USE_W),
    .HIST_W(HIST_W), .FILL_W(FILL_W), .AGE_W(AGE_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(lk_tag),
    .lk_hit(lk_hit), .lk_way(lk_way), .lk_use(lk_use), .lk_hist(lk_hist),
    .lk_fill(lk_fill), .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_idx(rs_idx), .rs_tag(rs_tag), .rs_main_miss(rs_main_miss),
    .rs_pat_ok(rs_pat_ok), .rs_pat_rdy(rs_pat_rdy), .rs_taken(rs_taken)
  );

  // behavioural reference state
  int m_vld [2][SETS], m_tag [2][SETS], m_use [2][SETS], m_hist [2][SETS], m_fill [2][SETS];
  int m_cnt, m_pend;
  int n_checks, n_fail;
  // observed lookup outputs of the last step
  int o_hit, o_way, o_use, o_hist, o_fill, o_rdy;

  task automatic check(input int act, input int exp, input string req, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < SETS; s++) begin
        m_vld[w][s] = 0; m_tag[w][s] = 0; m_use[w][s] = 0;
        m_hist[w][s] = 0; m_fill[w][s] = 0;
      end
    m_cnt = 0; m_pend = 0;
  endtask

  task automatic model_clock(input int v, input int i, input int t, input int mm,
                             input int pok, input int prdy, input int tk);
    int hw;
    if (m_pend) begin
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < SETS; s++) m_use[w][s] = 0;
      m_pend = 0;
      return;
    end
    if (!v) return;
    hw = -1;
    for (int w = 0; w < 2; w++)
      if (m_vld[w][i] && m_tag[w][i] == t) hw = w;
    if (hw >= 0) begin
      if (!prdy || (!pok && !mm)) begin
        if (m_use[hw][i] > 0) m_use[hw][i]--;
      end else if (pok && mm) begin
        if (m_use[hw][i] < UMAX) m_use[hw][i]++;
      end
      m_hist[hw][i] = ((m_hist[hw][i] << 1) | tk) & HMASK;
      if (m_fill[hw][i] < FMAX) m_fill[hw][i]++;
    end else if (mm) begin
      int vw;
      vw = (m_use[0][i] == 0) ? 0 : ((m_use[1][i] == 0) ? 1 : -1);
      if (vw >= 0) begin
        m_vld[vw][i] = 1; m_tag[vw][i] = t; m_use[vw][i] = UMAX;
        m_hist[vw][i] = 0; m_fill[vw][i] = 0;
      end
    end
    m_cnt++;
    if (m_cnt == (1 << AGE_W)) begin
      m_cnt = 0;
      m_pend = 1;
    end
  endtask

  // one clock: drive at the falling edge, compare, then advance the model at the rising edge
  task automatic step(input int li, input int lt, input int v, input int ri, input int rt,
                      input int mm, input int pok, input int prdy, input int tk);
    int ew, eh;
    @(negedge clk);
    lk_idx = SET_W'(li); lk_tag = TAG_W'(lt);
    rs_valid = v[0]; rs_idx = SET_W'(ri); rs_tag = TAG_W'(rt);
    rs_main_miss = mm[0]; rs_pat_ok = pok[0]; rs_pat_rdy = prdy[0]; rs_taken = tk[0];
    #1;
    o_hit = int'(lk_hit); o_way = int'(lk_way); o_use = int'(lk_use);
    o_hist = int'(lk_hist); o_fill = int'(lk_fill); o_rdy = int'(rs_ready);
    ew = -1;
    for (int w = 0; w < 2; w++)
      if (m_vld[w][li] && m_tag[w][li] == lt) ew = w;
    eh = (ew >= 0);
    check(o_hit, eh, "R11", "lookup hit");
    check(o_way, eh ? ew : 0, "R11", "lookup way");
    check(o_use, eh ? m_use[ew][li] : 0, "R6", "usefulness");
    check(o_hist, eh ? m_hist[ew][li] : 0, "R9", "history");
    check(o_fill, eh ? m_fill[ew][li] : 0, "R9", "fill count");
    check(o_rdy, !m_pend, "R10", "ready");
    @(posedge clk);
    model_clock(v, ri, rt, mm, pok, prdy, tk);
  endtask

  task automatic probe(input int li, input int lt);
    step(li, lt, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fail = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    for (int s = 0; s < SETS; s++) begin
      probe(s, 0);
      check(o_hit, 0, "R1", "hit after reset");
      check(o_use + o_hist + o_fill, 0, "R1", "zero outputs after reset");
      check(o_rdy, 1, "R1", "ready after reset");
    end

    // R3: miss with correct main prediction allocates nothing
    step(0, 0, 1, 1, 5, 0, 0, 1, 0);
    probe(1, 5);
    check(o_hit, 0, "R3", "no install without main miss");

    // R2, R4: first install goes to way 0 with fresh fields
    step(0, 0, 1, 1, 5, 1, 0, 1, 1);
    probe(1, 5);
    check(o_hit, 1, "R4", "installed");
    check(o_way, 0, "R2", "way 0 preferred");
    check(o_use, UMAX, "R4", "usefulness at max");
    check(o_hist + o_fill, 0, "R4", "history and fill cleared");

    step(0, 0, 1, 1, 9, 1, 0, 1, 0);
    probe(1, 9);
    check(o_way, 1, "R2", "second install to way 1");

    // R5: both ways busy
    step(0, 0, 1, 1, 11, 1, 0, 1, 0);
    probe(1, 11);
    check(o_hit, 0, "R5", "no install when both busy");

    // R8, R9: increment at max holds, history and fill advance
    step(0, 0, 1, 1, 5, 1, 1, 1, 1);
    probe(1, 5);
    check(o_use, UMAX, "R8", "saturate at max");
    check(o_hist, 1, "R9", "history shift");
    check(o_fill, 1, "R9", "fill step");

    // R7: not ready decrements
    step(0, 0, 1, 1, 5, 1, 1, 0, 0);
    probe(1, 5);
    check(o_use, UMAX - 1, "R7", "decrement when not ready");
    check(o_hist, 2, "R9", "history second shift");

    // R7: pattern wrong while main right
    step(0, 0, 1, 1, 5, 0, 0, 1, 1);
    probe(1, 5);
    check(o_use, UMAX - 2, "R7", "decrement on pattern loss");

    // R6: pattern right while main wrong, then both right holds
    step(0, 0, 1, 1, 5, 1, 1, 1, 1);
    probe(1, 5);
    check(o_use, UMAX - 1, "R6", "increment on pattern win");
    step(0, 0, 1, 1, 5, 0, 1, 1, 0);
    probe(1, 5);
    check(o_use, UMAX - 1, "R6", "hold when both right");

    // wear way 1 down, then replace it (R2), and R8 low saturation
    for (int k = 0; k < UMAX + 1; k++) step(0, 0, 1, 1, 9, 0, 0, 0, 0);
    probe(1, 9);
    check(o_use, 0, "R8", "saturate at zero");
    step(0, 0, 1, 1, 11, 1, 0, 1, 0);
    probe(1, 11);
    check(o_way, 1, "R2", "idle way 1 replaced");
    probe(1, 9);
    check(o_hit, 0, "R2", "evicted tag gone");

    // R10: run until the aging gap
    for (int k = 0; k < (1 << AGE_W) + 4; k++) begin
      step(1, 5, 1, 1, 5, 1, 1, 1, 1);
      if (o_rdy == 0) break;
    end
    check(o_rdy, 0, "R10", "ready gap seen");
    probe(1, 5);
    check(o_use, 0, "R10", "usefulness cleared");
    check(o_rdy, 1, "R10", "ready back");

    // random traffic against the model
    for (int k = 0; k < 4000; k++)
      step($urandom_range(SETS - 1), $urandom_range(3), int'($urandom_range(3) != 0),
           $urandom_range(SETS - 1), $urandom_range(3), $urandom_range(1),
           $urandom_range(1), int'($urandom_range(3) != 0), $urandom_range(1));

    finish_run();
  end

endmodule